// File: doc/BRIEF.md
# Real-Time Clock Alarm Comparator

This block sits beside the time-of-day counter of a real-time clock. Each time the counter finishes its once-per-second update, it pulses an update strobe. On that strobe the block compares the current second, minute and hour bytes with three alarm bytes. It then records two flags. The update-ended flag is set on every completed update. The alarm flag is set when every alarm field that is not a wildcard equals the current time.

The bytes can be stored in two ways, chosen by a mode input: two packed BCD digits or plain binary. The hour can be in 24-hour form, or in 12-hour form with bit 7 marking PM. Before comparing, the block converts both operands to one binary 24-hour value. An interrupt-request flag is raised only when a flag goes from clear to set and its enable input is high. A clear input models the read-to-clear of the flag register. The calendar counting itself lives elsewhere.

Top module: `rtc_alarm_cmp`

## Requirements
- R1: After reset, uf_o, af_o and irqf_o are 0.
- R2: An update strobe while div_ctl_i is not 2'b11 sets uf_o in the following cycle.
- R3: An accepted update also sets af_o when the second, minute and hour alarm bytes each equal the matching current byte after decoding, or are wildcards. In BCD mode (bin_mode_i=0) the tens digit is in bits 7:4 and the units digit is in bits 3:0.
- R4: An alarm byte with bits 7:6 both 1 (0xC0 to 0xFF) matches any current value of its field.
- R5: With bin_mode_i=1 every byte is compared as an unsigned binary number.
- R6: With hr24_i=0 the hour is in 12-hour form: bits 6:0 hold 1 to 12 and bit 7 means PM. 12 AM compares as hour 0, 12 PM compares as hour 12, and any other PM hour compares as that hour plus 12. This applies to both the current hour and the alarm hour.
- R7: An update strobe while div_ctl_i equals 2'b11 changes none of the flags.
- R8: While set_mode_i is 1 an update still sets uf_o, but af_o is not newly set.
- R9: irqf_o is set only in the cycle after uf_o goes from 0 to 1 with uie_i=1, or after af_o goes from 0 to 1 with aie_i=1. A flag that was already set raises no request.
- R10: clr_i clears all three flags in the following cycle. If an update arrives in the same cycle, the update is applied on top of the cleared state.
- R11: In any cycle without an update strobe or clr_i, the flags hold their values, whatever the time and alarm inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| upd_i | input | 1 | One-cycle pulse marking a completed time update |
| clr_i | input | 1 | Clears all flags (flag register read) |
| sec_i | input | 8 | Current seconds byte |
| min_i | input | 8 | Current minutes byte |
| hour_i | input | 8 | Current hours byte |
| alm_sec_i | input | 8 | Alarm seconds byte |
| alm_min_i | input | 8 | Alarm minutes byte |
| alm_hour_i | input | 8 | Alarm hours byte |
| bin_mode_i | input | 1 | 1: binary bytes, 0: BCD bytes |
| hr24_i | input | 1 | 1: 24-hour form, 0: 12-hour form with PM in bit 7 |
| set_mode_i | input | 1 | Time-setting mode; no new alarm match |
| uie_i | input | 1 | Enables a request on a newly set update flag |
| aie_i | input | 1 | Enables a request on a newly set alarm flag |
| div_ctl_i | input | 2 | Divider control; 2'b11 holds the divider and blocks updates |
| uf_o | output | 1 | Update-ended flag |
| af_o | output | 1 | Alarm flag |
| irqf_o | output | 1 | Interrupt request flag |

## Verification
Every result, whether a flag set, a flag clear or a request, is registered at the clock edge that samples the strobe or the clear. Each result is therefore due exactly one edge after its stimulus. The bench applies inputs on the falling edge. It holds the strobe or clear for one rising edge and reads the flags on the next falling edge, so every check lands on the first cycle in which the result is due. For the hold requirement, the bench keeps the strobe low for several further cycles while changing the inputs, then samples again to show that nothing moved.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned NUM_FIELDS = 3;
  localparam int unsigned HOUR_IDX   = 2;
  localparam int unsigned HALF_DAY   = 12;
  localparam logic [1:0]  DIV_HOLD   = 2'b11;

  // packed BCD or binary to binary
  function automatic logic [BYTE_W-1:0] field_value(input logic [BYTE_W-1:0] code,
                                                    input logic bin);
    logic [BYTE_W-1:0] tens, ones;
    tens = {4'd0, code[7:4]};
    ones = {4'd0, code[3:0]};
    return bin ? code : BYTE_W'(tens * BYTE_W'(10) + ones);
  endfunction

  function automatic logic is_wild(input logic [BYTE_W-1:0] code);
    return &code[BYTE_W-1:BYTE_W-2];
  endfunction
endpackage

// File: rtl/rtc_field_dec.sv
module rtc_field_dec
  import rtc_alarm_pkg::*;
#(
  parameter bit IS_HOUR = 1'b0
) (
  input  logic [BYTE_W-1:0] code_i,
  input  logic              bin_i,
  input  logic              hr24_i,
  output logic [BYTE_W-1:0] val_o
);
  generate
    if (IS_HOUR) begin : g_hour
      logic [BYTE_W-1:0] raw;
      logic              pm;
      always_comb begin
        raw = field_value({1'b0, code_i[BYTE_W-2:0]}, bin_i);
        pm  = code_i[BYTE_W-1];
        if (hr24_i)                        val_o = field_value(code_i, bin_i);
        else if (raw == BYTE_W'(HALF_DAY)) val_o = pm ? BYTE_W'(HALF_DAY) : '0;
        else                               val_o = pm ? raw + BYTE_W'(HALF_DAY) : raw;
      end
    end else begin : g_plain
      logic unused_hr24;
      assign unused_hr24 = hr24_i;
      assign val_o = field_value(code_i, bin_i);
    end
  endgenerate
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_alarm_pkg::*;
(
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] cur_i,
  input  logic [NUM_FIELDS-1:0][BYTE_W-1:0] alm_i,
  input  logic                              bin_i,
  input  logic                              hr24_i,
  output logic                              match_o
);
  logic [NUM_FIELDS-1:0] hit;

  generate
    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      logic [BYTE_W-1:0] cur_val, alm_val;
      rtc_field_dec #(.IS_HOUR(g == HOUR_IDX)) u_cur (
        .code_i(cur_i[g]), .bin_i(bin_i), .hr24_i(hr24_i), .val_o(cur_val));
      rtc_field_dec #(.IS_HOUR(g == HOUR_IDX)) u_alm (
        .code_i(alm_i[g]), .bin_i(bin_i), .hr24_i(hr24_i), .val_o(alm_val));
      assign hit[g] = is_wild(alm_i[g]) || (cur_val == alm_val);
    end
  endgenerate

  assign match_o = &hit;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_alarm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              clr_i,
  input  logic [BYTE_W-1:0] sec_i,
  input  logic [BYTE_W-1:0] min_i,
  input  logic [BYTE_W-1:0] hour_i,
  input  logic [BYTE_W-1:0] alm_sec_i,
  input  logic [BYTE_W-1:0] alm_min_i,
  input  logic [BYTE_W-1:0] alm_hour_i,
  input  logic              bin_mode_i,
  input  logic              hr24_i,
  input  logic              set_mode_i,
  input  logic              uie_i,
  input  logic              aie_i,
  input  logic [1:0]        div_ctl_i,
  output logic              uf_o,
  output logic              af_o,
  output logic              irqf_o
);
  logic match;
  logic upd_ok, set_uf, set_af;
  logic base_uf, base_af, base_irq;
  logic new_uf, new_af;
  logic uf_q, af_q, irq_q;

  rtc_alarm_match u_match (
    .cur_i  ({hour_i, min_i, sec_i}),
    .alm_i  ({alm_hour_i, alm_min_i, alm_sec_i}),
    .bin_i  (bin_mode_i),
    .hr24_i (hr24_i),
    .match_o(match)
  );

  always_comb begin
    upd_ok   = upd_i && (div_ctl_i != DIV_HOLD);
    set_uf   = upd_ok;
    set_af   = upd_ok && !set_mode_i && match;
    // clear is applied first, a same-cycle update lands on top
    base_uf  = clr_i ? 1'b0 : uf_q;
    base_af  = clr_i ? 1'b0 : af_q;
    base_irq = clr_i ? 1'b0 : irq_q;
    new_uf   = set_uf && !base_uf;
    new_af   = set_af && !base_af;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      uf_q  <= 1'b0;
      af_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      uf_q  <= base_uf | set_uf;
      af_q  <= base_af | set_af;
      irq_q <= base_irq | (new_uf & uie_i) | (new_af & aie_i);
    end
  end

  assign uf_o   = uf_q;
  assign af_o   = af_q;
  assign irqf_o = irq_q;
endmodule

// File: rtl/rtc_alarm_cmp_chk.sv
module rtc_alarm_cmp_chk
  import rtc_alarm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              upd_i,
  input logic              clr_i,
  input logic [BYTE_W-1:0] sec_i,
  input logic [BYTE_W-1:0] min_i,
  input logic [BYTE_W-1:0] hour_i,
  input logic [BYTE_W-1:0] alm_sec_i,
  input logic [BYTE_W-1:0] alm_min_i,
  input logic [BYTE_W-1:0] alm_hour_i,
  input logic              bin_mode_i,
  input logic              hr24_i,
  input logic              set_mode_i,
  input logic              uie_i,
  input logic              aie_i,
  input logic [1:0]        div_ctl_i,
  input logic              uf_o,
  input logic              af_o,
  input logic              irqf_o
);
  p_uf_from_upd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(uf_o) |-> $past(upd_i && div_ctl_i != DIV_HOLD));

  p_af_with_uf_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(af_o) |-> uf_o);

  p_div_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && div_ctl_i == DIV_HOLD && !clr_i) |=> ($stable(uf_o) && $stable(af_o) && $stable(irqf_o)));

  p_set_no_af_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && set_mode_i && !af_o && !clr_i) |=> !af_o);

  p_irq_enabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irqf_o) |-> $past(uie_i || aie_i));

  p_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !upd_i) |=> (!uf_o && !af_o && !irqf_o));

  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !clr_i) |=> ($stable(uf_o) && $stable(af_o) && $stable(irqf_o)));
endmodule

bind rtc_alarm_cmp rtc_alarm_cmp_chk u_chk (.*);

// File: tb/tb_rtc_alarm_cmp.sv
module tb_rtc_alarm_cmp;
  timeunit 1ns;
  timeprecision 1ps;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       upd_i = 1'b0, clr_i = 1'b0;
  logic [7:0] sec_i = '0, min_i = '0, hour_i = '0;
  logic [7:0] alm_sec_i = '0, alm_min_i = '0, alm_hour_i = '0;
  logic       bin_mode_i = 1'b0, hr24_i = 1'b1, set_mode_i = 1'b0;
  logic       uie_i = 1'b0, aie_i = 1'b0;
  logic [1:0] div_ctl_i = 2'b01;
  logic       uf_o, af_o, irqf_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  rtc_alarm_cmp dut (.*);

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  function automatic logic [7:0] enc(input int v, input bit bin);
    return bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [7:0] enc_hour(input int h, input bit bin, input bit h24);
    int h12;
    if (h24) return enc(h, bin);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return enc(h12, bin) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  task automatic pulse_clr();
    @(negedge clk_i); clr_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0;
  endtask

  task automatic pulse_upd();
    @(negedge clk_i); upd_i = 1'b1;
    @(negedge clk_i); upd_i = 1'b0;
  endtask

  task automatic run(input logic [7:0] cs, cm, ch, as_, am, ah);
    pulse_clr();
    sec_i = cs; min_i = cm; hour_i = ch;
    alm_sec_i = as_; alm_min_i = am; alm_hour_i = ah;
    pulse_upd();
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 uf", uf_o, 1'b0);
    check("R1 af", af_o, 1'b0);
    check("R1 irqf", irqf_o, 1'b0);
    rst_ni = 1'b1;

    // R2 plain update sets UF; R3 BCD full match 12:34:56
    run(8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12);
    check("R2 uf", uf_o, 1'b1);
    check("R3 af bcd match", af_o, 1'b1);
    check("R9 irqf disabled", irqf_o, 1'b0);
    run(8'h56, 8'h35, 8'h12, 8'h56, 8'h34, 8'h12);
    check("R3 af minute mismatch", af_o, 1'b0);

    // R11 hold: change inputs with no strobe
    run(8'h56, 8'h34, 8'h12, 8'h56, 8'h34, 8'h12);
    alm_sec_i = 8'h00; sec_i = 8'h11; bin_mode_i = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R11 af hold", af_o, 1'b1);
    check("R11 uf hold", uf_o, 1'b1);
    bin_mode_i = 1'b0;

    // R4/R5 seconds and minutes sweep with wildcards in both data modes
    for (int b = 0; b < 2; b++) begin
      bin_mode_i = b[0];
      for (int cs = 0; cs < 60; cs++) begin
        for (int k = 0; k < 4; k++) begin
          logic [7:0] a;
          bit exp;
          case (k)
            0: a = enc(cs, b[0]);
            1: a = enc((cs + 1) % 60, b[0]);
            2: a = 8'hC0;
            default: a = 8'hFF;
          endcase
          exp = (k != 1);
          run(enc(cs, b[0]), enc(7, b[0]), enc(3, b[0]), a, enc(7, b[0]), enc(3, b[0]));
          check(b ? "R5 sec binary" : "R4 sec wildcard/bcd", af_o, exp);
          run(enc(9, b[0]), enc(cs, b[0]), enc(3, b[0]), enc(9, b[0]), a, enc(3, b[0]));
          check(b ? "R5 min binary" : "R4 min wildcard/bcd", af_o, exp);
        end
      end
    end

    // R6 hour sweep over both data modes and both hour forms
    for (int b = 0; b < 2; b++) begin
      for (int f = 0; f < 2; f++) begin
        bin_mode_i = b[0]; hr24_i = f[0];
        for (int ch = 0; ch < 24; ch++) begin
          for (int ah = 0; ah < 24; ah++) begin
            run(8'h00, 8'h00, enc_hour(ch, b[0], f[0]),
                8'h00, 8'h00, enc_hour(ah, b[0], f[0]));
            check(f ? "R3 hour 24h" : "R6 hour 12h", af_o, ch == ah);
          end
          run(8'h00, 8'h00, enc_hour(ch, b[0], f[0]), 8'h00, 8'h00, 8'hC5);
          check("R4 hour wildcard", af_o, 1'b1);
        end
      end
    end
    bin_mode_i = 1'b0; hr24_i = 1'b0;
    // R6 12 AM must not match hour 12 (12 PM)
    run(8'h00, 8'h00, 8'h12, 8'h00, 8'h00, 8'h92);
    check("R6 12AM vs 12PM", af_o, 1'b0);
    hr24_i = 1'b1;

    // R7 divider held: nothing set
    div_ctl_i = 2'b11; uie_i = 1'b1; aie_i = 1'b1;
    run(8'h01, 8'h02, 8'h03, 8'h01, 8'h02, 8'h03);
    check("R7 uf", uf_o, 1'b0);
    check("R7 af", af_o, 1'b0);
    check("R7 irqf", irqf_o, 1'b0);
    div_ctl_i = 2'b10;
    run(8'h01, 8'h02, 8'h03, 8'h01, 8'h02, 8'h03);
    check("R2 uf other div", uf_o, 1'b1);
    div_ctl_i = 2'b01; uie_i = 1'b0; aie_i = 1'b0;

    // R8 set mode: UF yes, AF no
    set_mode_i = 1'b1;
    run(8'h01, 8'h02, 8'h03, 8'h01, 8'h02, 8'h03);
    check("R8 uf", uf_o, 1'b1);
    check("R8 af", af_o, 1'b0);
    set_mode_i = 1'b0;

    // R9 request only on newly set and enabled flags
    uie_i = 1'b1;
    run(8'h01, 8'h02, 8'h03, 8'h09, 8'h02, 8'h03);
    check("R9 irqf new uf", irqf_o, 1'b1);
    uie_i = 1'b0;
    run(8'h01, 8'h02, 8'h03, 8'h09, 8'h02, 8'h03);
    check("R9 irqf uf disabled", irqf_o, 1'b0);
    uie_i = 1'b1;
    pulse_upd();
    check("R9 irqf uf already set", irqf_o, 1'b0);
    uie_i = 1'b0; aie_i = 1'b1;
    alm_sec_i = 8'h01;
    pulse_upd();
    check("R9 irqf new af", irqf_o, 1'b1);
    aie_i = 1'b0;

    // R10 clear, and clear together with update
    pulse_clr();
    check("R10 uf", uf_o, 1'b0);
    check("R10 af", af_o, 1'b0);
    check("R10 irqf", irqf_o, 1'b0);
    pulse_upd();
    uie_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b1; upd_i = 1'b1;
    @(negedge clk_i); clr_i = 1'b0; upd_i = 1'b0;
    check("R10 uf clr+upd", uf_o, 1'b1);
    check("R10 irqf clr+upd", irqf_o, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule